// File: doc/BRIEF.md
# Thread Doorbell Controller

This block holds the doorbell interrupt state for a core of several hardware threads. The threads are split into equal groups, called subprocessors. Every thread can issue commands to the block. A command is one of these:

- a hypervisor-level send or clear;
- a privileged-level send or clear;
- a read or a write of a shared register.

Each command comes with the issuer's privilege state and a 32-bit message operand. For every thread the block keeps two pending bits: one for the hypervisor doorbell and one for the privileged doorbell.

Each subprocessor has a shared register that mirrors the privileged pending bits of its threads. Hypervisor state may read and write this register. Supervisor state may only read it, and only when the facility enable input is set. Supervisor use of a gated operation raises a one-cycle fault pulse.

Per thread, the block outputs an interrupt request and the class of the interrupt to take. The privileged class is taken first. The core acknowledges an interrupt with a take strobe, which clears the bit that was taken. Commands arriving in the same cycle are served one per cycle, and the lowest thread index goes first.

Top module: `doorbell_ctrl`

## Requirements
- R1: A send or clear command (op codes 0 to 3) changes state only when operand bits [31:27] equal 5. Any other value makes it a no-op with no fault.
- R2: Op 0 (hypervisor send), issued in hypervisor state, sets the hypervisor pending bit of the thread whose index equals operand bits [TAG_W-1:0]. A tag of NUM_THREADS or more changes nothing. Ops 0 and 1 issued in supervisor state change nothing and raise no fault.
- R3: Op 2 (privileged send) sets the privileged pending bit of the tagged thread only if that thread is in the issuer's subprocessor (thread t is in group t / SUB_THREADS). Otherwise it changes nothing.
- R4: Op 3 (privileged clear) clears only the issuer's privileged pending bit. Op 1 (hypervisor clear, hypervisor state) clears only the issuer's hypervisor pending bit.
- R5: An accepted op 4 (register read) that is permitted sets rdValid in the next cycle. In that cycle, rdData bit i holds the privileged pending bit of thread (group base + i), as it stood before that cycle's updates, and respThread holds the issuer's index.
- R6: A supervisor read with facEnable at 0 raises faultPulse for one cycle, with respThread set to the issuer, and does not raise rdValid. A supervisor write (op 5) always faults and changes nothing.
- R7: Op 5 in hypervisor state writes operand bit i into the privileged pending bit of thread (group base + i) of the issuer's group. A 1 sets the bit and raises its interrupt; a 0 clears it.
- R8: Op 2 or op 3 issued in supervisor state with facEnable at 0 raises faultPulse and changes no pending bit.
- R9: irqReq[t] is high while either pending bit of thread t is set. irqHyp[t] is high only when the hypervisor bit alone is pending. intTake[t] clears the privileged bit if it is set, and otherwise clears the hypervisor bit.
- R10: cmdReady is high only for the lowest-index thread with cmdValid high. Other requests wait until they are served. Op codes 6 and 7 are accepted and ignored.
- R11: A set and a clear (from a take or a clear command) that hit the same bit in the same cycle leave the bit set. A register write of 1 likewise overrides a take.
- R12: Reset clears all pending bits, and all outputs read 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | NUM_THREADS | Command request, one bit per thread |
| cmdOp | input | 3*NUM_THREADS | Op code of thread t in bits [3t+2:3t] |
| cmdHyp | input | NUM_THREADS | Issuer is in hypervisor state |
| cmdOperand | input | 32*NUM_THREADS | Message operand of thread t in bits [32t+31:32t] |
| facEnable | input | 1 | Enables supervisor use of the privileged facility |
| intTake | input | NUM_THREADS | Core takes the signalled interrupt of thread t |
| cmdReady | output | NUM_THREADS | Command of thread t is accepted this cycle |
| irqReq | output | NUM_THREADS | Doorbell interrupt pending for thread t |
| irqHyp | output | NUM_THREADS | Pending interrupt is of the hypervisor class |
| rdValid | output | 1 | Register read data valid |
| rdData | output | SUB_THREADS | Shared register contents |
| respThread | output | TAG_W | Thread that the read or fault belongs to |
| faultPulse | output | 1 | Facility-unavailable fault |

## Verification
The hardest case to reach is a set and a clear landing on the same bit in one cycle. The clear can be a take on a thread that already has its privileged bit pending, or a register write of 1 in the same cycle as a take. To create it, the stimulus first arms the bit with one command and then issues the send or write in the cycle that the take strobe fires.

Random cycles drive many threads at once with a mostly valid type field, tags that include nonexistent threads, and random privilege and enable levels. This also produces groups that are crossed and commands that are held back by arbitration.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  localparam int OPER_W   = 32;
  localparam int TYPE_LSB = 27;
  localparam int TYPE_W   = 5;
  localparam logic [TYPE_W-1:0] MSG_TYPE_DBELL = 5'd5;

  typedef enum logic [2:0] {
    OP_HV_SEND = 3'd0,
    OP_HV_CLR  = 3'd1,
    OP_PR_SEND = 3'd2,
    OP_PR_CLR  = 3'd3,
    OP_REG_RD  = 3'd4,
    OP_REG_WR  = 3'd5
  } dbOp_e;

  // strobes from decode to the state datapath
  typedef struct packed {
    logic setHv;
    logic clrHv;
    logic setPriv;
    logic clrPriv;
    logic regWr;
    logic regRd;
    logic fault;
  } dbStrobe_t;

endpackage

// File: rtl/doorbell_arb.sv
module doorbell_arb #(
  parameter int NUM_THREADS = 6,
  localparam int IDX_W = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] req,
  output logic [NUM_THREADS-1:0] gnt,
  output logic [IDX_W-1:0]       gntIdx,
  output logic                   anyGnt
);

  // fixed priority: the lowest index wins, so scan downward
  always_comb begin
    gnt    = '0;
    gntIdx = '0;
    anyGnt = 1'b0;
    for (int t = NUM_THREADS - 1; t >= 0; t--) begin
      if (req[t]) begin
        gnt    = '0;
        gnt[t] = 1'b1;
        gntIdx = IDX_W'(t);
        anyGnt = 1'b1;
      end
    end
  end

endmodule

// File: rtl/doorbell_ctl.sv
module doorbell_ctl
  import doorbell_pkg::*;
#(
  parameter int NUM_THREADS = 6,
  parameter int SUB_THREADS = 3,
  localparam int IDX_W = $clog2(NUM_THREADS)
) (
  input  logic                          anyGnt,
  input  logic [IDX_W-1:0]              gntIdx,
  input  logic [3*NUM_THREADS-1:0]      cmdOp,
  input  logic [NUM_THREADS-1:0]        cmdHyp,
  input  logic [OPER_W*NUM_THREADS-1:0] cmdOperand,
  input  logic                          facEnable,
  output dbStrobe_t                     strobe,
  output logic [IDX_W-1:0]              tgtIdx,
  output logic [SUB_THREADS-1:0]        wrBits
);

  logic [2:0]        selOp;
  logic              selHyp;
  logic [OPER_W-1:0] selOperand;
  logic [IDX_W-1:0]  tag;
  logic              typeOk, tagOk, sameSub, facDenied;
  logic              unusedOperandBits;

  // route the granted thread's command
  always_comb begin
    selOp      = '0;
    selHyp     = 1'b0;
    selOperand = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (gntIdx == IDX_W'(t)) begin
        selOp      = cmdOp[3*t +: 3];
        selHyp     = cmdHyp[t];
        selOperand = cmdOperand[OPER_W*t +: OPER_W];
      end
    end
  end

  assign tag       = selOperand[IDX_W-1:0];
  assign wrBits    = selOperand[SUB_THREADS-1:0];
  assign typeOk    = selOperand[TYPE_LSB +: TYPE_W] == MSG_TYPE_DBELL;
  assign tagOk     = int'(tag) < NUM_THREADS;
  assign sameSub   = (int'(tag) / SUB_THREADS) == (int'(gntIdx) / SUB_THREADS);
  assign facDenied = !selHyp && !facEnable;
  assign unusedOperandBits = ^selOperand[TYPE_LSB-1:IDX_W];

  always_comb begin
    strobe = '0;
    tgtIdx = gntIdx;
    if (anyGnt) begin
      case (selOp)
        OP_HV_SEND: begin
          if (selHyp && typeOk && tagOk) begin
            strobe.setHv = 1'b1;
            tgtIdx       = tag;
          end
        end
        OP_HV_CLR: begin
          if (selHyp && typeOk) strobe.clrHv = 1'b1;
        end
        OP_PR_SEND: begin
          if (facDenied) strobe.fault = 1'b1;
          else if (typeOk && tagOk && sameSub) begin
            strobe.setPriv = 1'b1;
            tgtIdx         = tag;
          end
        end
        OP_PR_CLR: begin
          if (facDenied) strobe.fault = 1'b1;
          else if (typeOk) strobe.clrPriv = 1'b1;
        end
        OP_REG_RD: begin
          if (facDenied) strobe.fault = 1'b1;
          else strobe.regRd = 1'b1;
        end
        OP_REG_WR: begin
          if (selHyp) strobe.regWr = 1'b1;
          else strobe.fault = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/doorbell_dp.sv
module doorbell_dp
  import doorbell_pkg::*;
#(
  parameter int NUM_THREADS = 6,
  parameter int SUB_THREADS = 3,
  localparam int IDX_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dbStrobe_t              strobe,
  input  logic [IDX_W-1:0]       srcIdx,
  input  logic [IDX_W-1:0]       tgtIdx,
  input  logic [SUB_THREADS-1:0] wrBits,
  input  logic [NUM_THREADS-1:0] intTake,
  output logic [NUM_THREADS-1:0] irqReq,
  output logic [NUM_THREADS-1:0] irqHyp,
  output logic                   rdValid,
  output logic [SUB_THREADS-1:0] rdData,
  output logic [IDX_W-1:0]       respThread,
  output logic                   faultPulse
);

  logic [NUM_THREADS-1:0] hvPend, prPend, hvNext, prNext;
  logic [SUB_THREADS-1:0] rdNext;
  int                     srcGroup;

  assign srcGroup = int'(srcIdx) / SUB_THREADS;

  // later assignments take precedence: take/clear, then write, then set
  always_comb begin
    hvNext = hvPend;
    prNext = prPend;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (intTake[t]) begin
        if (prPend[t]) prNext[t] = 1'b0;
        else if (hvPend[t]) hvNext[t] = 1'b0;
      end
      if (strobe.clrPriv && srcIdx == IDX_W'(t)) prNext[t] = 1'b0;
      if (strobe.clrHv && srcIdx == IDX_W'(t)) hvNext[t] = 1'b0;
      if (strobe.regWr && srcGroup == t / SUB_THREADS)
        prNext[t] = wrBits[t % SUB_THREADS];
      if (strobe.setPriv && tgtIdx == IDX_W'(t)) prNext[t] = 1'b1;
      if (strobe.setHv && tgtIdx == IDX_W'(t)) hvNext[t] = 1'b1;
    end
  end

  always_comb begin
    rdNext = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (srcGroup == t / SUB_THREADS) rdNext[t % SUB_THREADS] = prPend[t];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hvPend     <= '0;
      prPend     <= '0;
      rdValid    <= 1'b0;
      rdData     <= '0;
      respThread <= '0;
      faultPulse <= 1'b0;
    end else begin
      hvPend     <= hvNext;
      prPend     <= prNext;
      rdValid    <= strobe.regRd;
      faultPulse <= strobe.fault;
      if (strobe.regRd) rdData <= rdNext;
      if (strobe.regRd || strobe.fault) respThread <= srcIdx;
    end
  end

  assign irqReq = prPend | hvPend;
  assign irqHyp = hvPend & ~prPend;

endmodule

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import doorbell_pkg::*;
#(
  parameter int NUM_THREADS = 6,
  parameter int SUB_THREADS = 3,
  localparam int IDX_W = $clog2(NUM_THREADS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_THREADS-1:0]        cmdValid,
  input  logic [3*NUM_THREADS-1:0]      cmdOp,
  input  logic [NUM_THREADS-1:0]        cmdHyp,
  input  logic [OPER_W*NUM_THREADS-1:0] cmdOperand,
  input  logic                          facEnable,
  input  logic [NUM_THREADS-1:0]        intTake,
  output logic [NUM_THREADS-1:0]        cmdReady,
  output logic [NUM_THREADS-1:0]        irqReq,
  output logic [NUM_THREADS-1:0]        irqHyp,
  output logic                          rdValid,
  output logic [SUB_THREADS-1:0]        rdData,
  output logic [IDX_W-1:0]              respThread,
  output logic                          faultPulse
);

  logic [IDX_W-1:0]       gntIdx, tgtIdx;
  logic                   anyGnt;
  logic [SUB_THREADS-1:0] wrBits;
  dbStrobe_t              strobe;

  doorbell_arb #(.NUM_THREADS(NUM_THREADS)) u_arb (
    .req    (cmdValid),
    .gnt    (cmdReady),
    .gntIdx (gntIdx),
    .anyGnt (anyGnt)
  );

  doorbell_ctl #(.NUM_THREADS(NUM_THREADS), .SUB_THREADS(SUB_THREADS)) u_ctl (
    .anyGnt     (anyGnt),
    .gntIdx     (gntIdx),
    .cmdOp      (cmdOp),
    .cmdHyp     (cmdHyp),
    .cmdOperand (cmdOperand),
    .facEnable  (facEnable),
    .strobe     (strobe),
    .tgtIdx     (tgtIdx),
    .wrBits     (wrBits)
  );

  doorbell_dp #(.NUM_THREADS(NUM_THREADS), .SUB_THREADS(SUB_THREADS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srcIdx     (gntIdx),
    .tgtIdx     (tgtIdx),
    .wrBits     (wrBits),
    .intTake    (intTake),
    .irqReq     (irqReq),
    .irqHyp     (irqHyp),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .respThread (respThread),
    .faultPulse (faultPulse)
  );

endmodule

// File: rtl/doorbell_checker.sv
module doorbell_checker #(
  parameter int NUM_THREADS = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_THREADS-1:0] cmdValid,
  input logic [NUM_THREADS-1:0] cmdReady,
  input logic [NUM_THREADS-1:0] irqReq,
  input logic [NUM_THREADS-1:0] irqHyp,
  input logic                   rdValid,
  input logic                   faultPulse
);

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdReady));

  p_ready_needs_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady & ~cmdValid) == '0);

  p_lowest_served_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid[0] |-> cmdReady[0]);

  p_hyp_class_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqHyp & ~irqReq) == '0);

  p_resp_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && faultPulse));

  p_read_follows_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|cmdReady) == 1'b0 |=> !rdValid && !faultPulse);

endmodule

bind doorbell_ctrl doorbell_checker #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdReady   (cmdReady),
  .irqReq     (irqReq),
  .irqHyp     (irqHyp),
  .rdValid    (rdValid),
  .faultPulse (faultPulse)
);

// File: tb/test_doorbell_ctrl.sv
module test_doorbell_ctrl;

  localparam int  N          = 6;
  localparam int  SUB        = 3;
  localparam int  IW         = 3;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rstN;
  logic [N-1:0]    vld, hyp, take;
  logic [3*N-1:0]  opv;
  logic [32*N-1:0] oper;
  logic            fac;
  logic [N-1:0]    cmdReady, irqReq, irqHyp;
  logic            rdValid, faultPulse;
  logic [SUB-1:0]  rdData;
  logic [IW-1:0]   respThread;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [N-1:0]   mHv = '0, mPr = '0;
  logic           eRd = 0, eFlt = 0;
  logic [SUB-1:0] eRdData = '0;
  logic [IW-1:0]  eResp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_ctrl #(.NUM_THREADS(N), .SUB_THREADS(SUB)) i_doorbell_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(vld), .cmdOp(opv), .cmdHyp(hyp),
    .cmdOperand(oper), .facEnable(fac), .intTake(take), .cmdReady(cmdReady),
    .irqReq(irqReq), .irqHyp(irqHyp), .rdValid(rdValid), .rdData(rdData),
    .respThread(respThread), .faultPulse(faultPulse)
  );

  function automatic logic [31:0] mkOp(int typ, int tag);
    return {5'(typ), 27'(tag)};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    vld = '0; hyp = '0; take = '0; opv = '0; oper = '0; fac = 1'b0;
  endtask

  task automatic setCmd(int t, int op, bit h, logic [31:0] o);
    vld[t] = 1'b1;
    opv[3*t +: 3] = 3'(op);
    hyp[t] = h;
    oper[32*t +: 32] = o;
  endtask

  // reference model per the requirements
  task automatic modelStep(output logic [N-1:0] expReady);
    int g = -1;
    logic [N-1:0] nHv = mHv, nPr = mPr;
    for (int t = N - 1; t >= 0; t--) if (vld[t]) g = t;
    expReady = '0;
    eRd = 0; eFlt = 0;
    for (int t = 0; t < N; t++)
      if (take[t]) begin
        if (mPr[t]) nPr[t] = 0; else if (mHv[t]) nHv[t] = 0;
      end
    if (g >= 0) begin
      logic [2:0]  op = opv[3*g +: 3];
      bit          h  = hyp[g];
      logic [31:0] o  = oper[32*g +: 32];
      bit          typeOk = (o[31:27] == 5'd5);
      int          tag = int'(o[IW-1:0]);
      bit          tagOk = tag < N;
      bit          denied = !h && !fac;
      expReady[g] = 1'b1;
      case (op)
        3'd0: if (h && typeOk && tagOk) nHv[tag] = 1;
        3'd1: if (h && typeOk) nHv[g] = 0;
        3'd2: if (denied) eFlt = 1;
              else if (typeOk && tagOk && (tag / SUB == g / SUB)) nPr[tag] = 1;
        3'd3: if (denied) eFlt = 1; else if (typeOk) nPr[g] = 0;
        3'd4: if (denied) eFlt = 1;
              else begin
                eRd = 1;
                for (int i = 0; i < SUB; i++) eRdData[i] = mPr[(g / SUB) * SUB + i];
              end
        3'd5: if (!h) eFlt = 1;
              else for (int i = 0; i < SUB; i++) nPr[(g / SUB) * SUB + i] = o[i];
        default: ;
      endcase
      if (eRd || eFlt) eResp = IW'(g);
    end
    mHv = nHv; mPr = nPr;
  endtask

  // inputs are set at a falling edge; this runs one clock cycle
  task automatic runCycle(string req);
    logic [N-1:0] expReady;
    #1;
    modelStep(expReady);
    chk({req, "/R10"}, "cmdReady", 32'(cmdReady), 32'(expReady));
    @(posedge clk);
    #1;
    chk({req, "/R9"}, "irqReq", 32'(irqReq), 32'(mHv | mPr));
    chk({req, "/R9"}, "irqHyp", 32'(irqHyp), 32'(mHv & ~mPr));
    chk({req, "/R5"}, "rdValid", 32'(rdValid), 32'(eRd));
    chk({req, "/R6"}, "faultPulse", 32'(faultPulse), 32'(eFlt));
    if (eRd) chk({req, "/R5"}, "rdData", 32'(rdData), 32'(eRdData));
    if (eRd || eFlt) chk({req, "/R5"}, "respThread", 32'(respThread), 32'(eResp));
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_d00b));
    clearIn();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk("R12", "irqReq", 32'(irqReq), 0);
    chk("R12", "irqHyp", 32'(irqHyp), 0);
    chk("R12", "rdValid/fault", {30'd0, rdValid, faultPulse}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: hypervisor send to thread 4
    clearIn(); setCmd(0, 0, 1, mkOp(5, 4)); runCycle("R2");
    // R1: wrong type field is ignored
    clearIn(); setCmd(0, 0, 1, mkOp(4, 2)); runCycle("R1");
    clearIn(); setCmd(1, 3, 1, mkOp(6, 1)); runCycle("R1");
    // R2: nonexistent tag and supervisor issuer
    clearIn(); setCmd(0, 0, 1, mkOp(5, 7)); runCycle("R2");
    clearIn(); setCmd(0, 0, 0, mkOp(5, 1)); fac = 1; runCycle("R2");
    // R3: cross-group send ignored, same-group send lands
    clearIn(); setCmd(1, 2, 0, mkOp(5, 4)); fac = 1; runCycle("R3");
    clearIn(); setCmd(1, 2, 0, mkOp(5, 2)); fac = 1; runCycle("R3");
    // R9: thread 4 gets privileged on top of hypervisor, then takes
    clearIn(); setCmd(3, 2, 1, mkOp(5, 4)); runCycle("R9");
    clearIn(); take[4] = 1; runCycle("R9");
    clearIn(); take[4] = 1; runCycle("R9");
    // R6: gated supervisor read, then enabled read
    clearIn(); setCmd(0, 4, 0, 0); runCycle("R6");
    clearIn(); setCmd(0, 4, 0, 0); fac = 1; runCycle("R6");
    clearIn(); setCmd(0, 5, 0, mkOp(0, 7)); fac = 1; runCycle("R6");
    // R7: hypervisor write to group 1, read back
    clearIn(); setCmd(3, 5, 1, 32'b101); runCycle("R7");
    clearIn(); setCmd(4, 4, 1, 0); runCycle("R7");
    // R8: supervisor clear with facility off faults
    clearIn(); setCmd(3, 3, 0, mkOp(5, 0)); runCycle("R8");
    clearIn(); setCmd(5, 2, 0, mkOp(5, 4)); runCycle("R8");
    // R4: clear hits issuer only
    clearIn(); setCmd(3, 3, 1, mkOp(5, 5)); runCycle("R4");
    clearIn(); setCmd(0, 0, 1, mkOp(5, 1)); runCycle("R4");
    clearIn(); setCmd(1, 1, 1, mkOp(5, 0)); runCycle("R4");
    // R11: send and take on the same bit
    clearIn(); setCmd(0, 2, 1, mkOp(5, 1)); runCycle("R11");
    clearIn(); setCmd(0, 2, 1, mkOp(5, 1)); take[1] = 1; runCycle("R11");
    clearIn(); setCmd(4, 5, 1, 32'b111); take[5] = 1; runCycle("R11");
    // R10: lower index served first, the other waits
    clearIn(); setCmd(1, 4, 1, 0); setCmd(3, 4, 1, 0); runCycle("R10");
    clearIn(); setCmd(3, 4, 1, 0); runCycle("R10");
    clearIn(); setCmd(2, 7, 1, mkOp(5, 0)); runCycle("R10");

    // constrained random traffic
    for (int c = 0; c < 3000; c++) begin
      clearIn();
      fac = 1'($urandom_range(0, 1));
      for (int t = 0; t < N; t++) begin
        if ($urandom_range(0, 1) == 1) begin
          int typ = ($urandom_range(0, 3) != 0) ? 5 : int'($urandom_range(0, 31));
          setCmd(t, int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 mkOp(typ, int'($urandom_range(0, 7))));
        end
        take[t] = ($urandom_range(0, 3) == 0);
      end
      runCycle("RND");
    end

    finishRun();
  end

endmodule